// File: doc/BRIEF.md
# Register Busy Scoreboard

This block keeps one busy bit for each architectural register of a single-issue, in-order core. A bit is 1 while a result for that register is still in flight. The issue stage marks the destinations of an instruction as busy when it dispatches it. Writeback clears the bit when the result lands. The issue stage also reads the whole vector back, and it receives a single hazard flag for the instruction waiting to go.

Writers do not pass binary register numbers. Each write port carries a unary selection vector: one wire per register, with at most one wire high. A set/clear bit goes with it. There are two such ports, so an instruction with two destinations can mark both in one cycle. An example is a load that also updates its base register. Writeback can also release one register while issue claims another. The hazard check takes up to three source-operand selections and two destination selections. Each selection is a unary vector, and all-zero means the operand slot is unused.

The entry count and the number of ports and operand slots are parameters. The default instance covers a 32-entry integer file. A narrower instance can track condition-register fields.

Top module: `reg_busy_sb`

## Requirements
- R1: A synchronous, active-high `rst` sampled at a rising edge makes every bit of `busy_vec` 0 after that edge.
- R2: A port `p` with `wr_en[p]=1`, `wr_val[p]=1` and a one-hot `wr_sel[p]` with bit k high sets bit k of `busy_vec` after the next rising edge. The other bits are unchanged unless some other port writes them.
- R3: A port with `wr_en[p]=1`, `wr_val[p]=0` and bit k high in `wr_sel[p]` clears bit k of `busy_vec` after the next rising edge.
- R4: The two write ports act independently in the same cycle. Writes to two different entries both take effect at the same edge.
- R5: When one port sets entry k and the other clears entry k in the same cycle, entry k is 0 after the edge. This holds whichever port carries the clear.
- R6: `busy_vec` and `hazard` come from registered state only. A write presented in a cycle is not visible on either output before the next rising edge.
- R7: A port with `wr_en[p]=0` changes no entry, whatever its `wr_sel[p]` and `wr_val[p]` hold.
- R8: `hazard` is 1 exactly when some bit that is high in any of the three `src_sel` vectors or the two `dst_sel` vectors is also high in `busy_vec`. With all selections zero, `hazard` is 0.
- R9: With no port enabled, `busy_vec` keeps its value from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | NUM_WP | Per-port write enable |
| wr_sel | input | NUM_WP x NUM_ENT | Per-port unary entry selection |
| wr_val | input | NUM_WP | Per-port data: 1 marks busy, 0 releases |
| src_sel | input | NUM_SRC x NUM_ENT | Unary selection of each source operand, zero when unused |
| dst_sel | input | NUM_DST x NUM_ENT | Unary selection of each destination operand, zero when unused |
| busy_vec | output | NUM_ENT | Registered busy bits, one per register |
| hazard | output | 1 | Candidate instruction touches a busy register |

## Verification
The bench sweeps every entry through set and clear on both ports. It then drives paired writes to distinct entries, which a design that served only one port per cycle would drop. Same-entry set/clear collisions are tried in both port orders; a design with set priority, or with a fixed port priority, leaves the bit stuck busy. Disabled ports drive all-ones selections to catch enables that are ignored. The bench also looks at the outputs before the edge, so any write-to-read bypass shows up early. The hazard check walks every operand slot across every entry against a mixed busy pattern, which exposes a slot left out of the reduction or a bit that is mis-wired.

// File: rtl/sb_pkg.sv
`timescale 1ns/1ps
package sb_pkg;
   // Meaning of the data bit carried by each write port.
   typedef enum logic {
      WR_RELEASE = 1'b0,
      WR_CLAIM   = 1'b1
   } wr_op_e;

   // Smallest legal entry count for a scoreboard instance.
   localparam int unsigned MIN_ENTRIES = 2;
endpackage

// File: rtl/sb_port_decode.sv
`timescale 1ns/1ps
// Splits one unary write port into a set mask and a clear mask.
module sb_port_decode
   import sb_pkg::*;
#(
   parameter int unsigned NUM_ENT = 32
) (
   input  logic               en,
   input  logic [NUM_ENT-1:0] sel,
   input  logic               val,
   output logic [NUM_ENT-1:0] set_mask,
   output logic [NUM_ENT-1:0] clr_mask
);
   wr_op_e op;

   always_comb begin
      op       = wr_op_e'(val);
      set_mask = '0;
      clr_mask = '0;
      if (en) begin
         if (op == WR_CLAIM) set_mask = sel;
         else                clr_mask = sel;
      end
   end
endmodule

// File: rtl/sb_entry.sv
`timescale 1ns/1ps
// One busy bit. Any release request beats any claim request.
module sb_entry #(
   parameter int unsigned NUM_WP = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NUM_WP-1:0] set_req,
   input  logic [NUM_WP-1:0] clr_req,
   output logic              busy
);
   always_ff @(posedge clk) begin
      if (rst)             busy <= 1'b0;
      else if (|clr_req)   busy <= 1'b0;
      else if (|set_req)   busy <= 1'b1;
   end
endmodule

// File: rtl/sb_hazard.sv
`timescale 1ns/1ps
// Folds every operand selection into one mask and tests it against the state.
module sb_hazard #(
   parameter int unsigned NUM_ENT = 32,
   parameter int unsigned NUM_SRC = 3,
   parameter int unsigned NUM_DST = 2
) (
   input  logic [NUM_SRC-1:0][NUM_ENT-1:0] src_sel,
   input  logic [NUM_DST-1:0][NUM_ENT-1:0] dst_sel,
   input  logic [NUM_ENT-1:0]              busy,
   output logic                            hazard
);
   localparam int unsigned NUM_OPS = NUM_SRC + NUM_DST;

   logic [NUM_OPS-1:0][NUM_ENT-1:0] op_sel;
   logic [NUM_ENT-1:0]              touch;

   genvar gs, gd;
   generate
      for (gs = 0; gs < NUM_SRC; gs++) begin : g_src
         assign op_sel[gs] = src_sel[gs];
      end
      for (gd = 0; gd < NUM_DST; gd++) begin : g_dst
         assign op_sel[NUM_SRC+gd] = dst_sel[gd];
      end
   endgenerate

   always_comb begin
      touch = '0;
      for (int i = 0; i < NUM_OPS; i++) touch |= op_sel[i];
      hazard = |(touch & busy);
   end
endmodule

// File: rtl/reg_busy_sb.sv
`timescale 1ns/1ps
// Register busy scoreboard: unary-addressed, multi-port write, full-vector read.
module reg_busy_sb
   import sb_pkg::*;
#(
   parameter int unsigned NUM_ENT = 32,
   parameter int unsigned NUM_WP  = 2,
   parameter int unsigned NUM_SRC = 3,
   parameter int unsigned NUM_DST = 2
) (
   input  logic                            clk,
   input  logic                            rst,
   input  logic [NUM_WP-1:0]               wr_en,
   input  logic [NUM_WP-1:0][NUM_ENT-1:0]  wr_sel,
   input  logic [NUM_WP-1:0]               wr_val,
   input  logic [NUM_SRC-1:0][NUM_ENT-1:0] src_sel,
   input  logic [NUM_DST-1:0][NUM_ENT-1:0] dst_sel,
   output logic [NUM_ENT-1:0]              busy_vec,
   output logic                            hazard
);
   // Elaboration-time parameter checks.
   generate
      if (NUM_ENT < MIN_ENTRIES) begin : g_bad_ent
         $error("reg_busy_sb: NUM_ENT below minimum");
      end
      if (NUM_WP < 1) begin : g_bad_wp
         $error("reg_busy_sb: need at least one write port");
      end
      if (NUM_SRC < 1 || NUM_DST < 1) begin : g_bad_ops
         $error("reg_busy_sb: operand slot counts must be nonzero");
      end
   endgenerate

   logic [NUM_WP-1:0][NUM_ENT-1:0] port_set;
   logic [NUM_WP-1:0][NUM_ENT-1:0] port_clr;
   logic [NUM_ENT-1:0][NUM_WP-1:0] ent_set;
   logic [NUM_ENT-1:0][NUM_WP-1:0] ent_clr;
   logic [NUM_ENT-1:0]             state_q;

   genvar gp, ge;
   generate
      for (gp = 0; gp < NUM_WP; gp++) begin : g_port
         sb_port_decode #(.NUM_ENT(NUM_ENT)) dec_i (
            .en       (wr_en[gp]),
            .sel      (wr_sel[gp]),
            .val      (wr_val[gp]),
            .set_mask (port_set[gp]),
            .clr_mask (port_clr[gp])
         );
      end

      for (ge = 0; ge < NUM_ENT; ge++) begin : g_ent
         for (gp = 0; gp < NUM_WP; gp++) begin : g_col
            assign ent_set[ge][gp] = port_set[gp][ge];
            assign ent_clr[ge][gp] = port_clr[gp][ge];
         end
         sb_entry #(.NUM_WP(NUM_WP)) ent_i (
            .clk     (clk),
            .rst     (rst),
            .set_req (ent_set[ge]),
            .clr_req (ent_clr[ge]),
            .busy    (state_q[ge])
         );
      end
   endgenerate

   assign busy_vec = state_q;

   sb_hazard #(
      .NUM_ENT (NUM_ENT),
      .NUM_SRC (NUM_SRC),
      .NUM_DST (NUM_DST)
   ) hz_i (
      .src_sel (src_sel),
      .dst_sel (dst_sel),
      .busy    (state_q),
      .hazard  (hazard)
   );
endmodule

// File: rtl/reg_busy_sb_chk.sv
`timescale 1ns/1ps
module reg_busy_sb_chk #(
   parameter int unsigned NUM_ENT = 32,
   parameter int unsigned NUM_WP  = 2,
   parameter int unsigned NUM_SRC = 3,
   parameter int unsigned NUM_DST = 2
) (
   input logic                            clk,
   input logic                            rst,
   input logic [NUM_WP-1:0]               wr_en,
   input logic [NUM_WP-1:0][NUM_ENT-1:0]  wr_sel,
   input logic [NUM_WP-1:0]               wr_val,
   input logic [NUM_SRC-1:0][NUM_ENT-1:0] src_sel,
   input logic [NUM_DST-1:0][NUM_ENT-1:0] dst_sel,
   input logic [NUM_ENT-1:0]              busy_vec,
   input logic                            hazard
);
   logic [NUM_ENT-1:0] set_any, clr_any, set_only, op_any;

   always_comb begin
      set_any = '0;
      clr_any = '0;
      op_any  = '0;
      for (int p = 0; p < NUM_WP; p++) begin
         if (wr_en[p] &&  wr_val[p]) set_any |= wr_sel[p];
         if (wr_en[p] && !wr_val[p]) clr_any |= wr_sel[p];
      end
      for (int s = 0; s < NUM_SRC; s++) op_any |= src_sel[s];
      for (int d = 0; d < NUM_DST; d++) op_any |= dst_sel[d];
      set_only = set_any & ~clr_any;
   end

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (busy_vec == '0)); // R1

   AST_SET_LANDS: assert property (@(posedge clk) disable iff (rst)
      !rst |=> ((busy_vec & $past(set_only)) == $past(set_only))); // R2

   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
      !rst |=> ((busy_vec & $past(clr_any)) == '0)); // R5

   AST_UNTOUCHED_HOLDS: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (((busy_vec ^ $past(busy_vec)) & ~$past(set_any | clr_any)) == '0)); // R7

   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
      (wr_en == '0) |=> $stable(busy_vec)); // R9

   AST_NO_OPERANDS_NO_HAZARD: assert property (@(posedge clk) disable iff (rst)
      (op_any == '0) |-> !hazard); // R8

   AST_HAZARD_NEEDS_OVERLAP: assert property (@(posedge clk) disable iff (rst)
      hazard |-> ((op_any & busy_vec) != '0)); // R8

   genvar gp;
   generate
      for (gp = 0; gp < NUM_WP; gp++) begin : g_sel
         AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
            wr_en[gp] |-> $onehot0(wr_sel[gp])); // R2
      end
   endgenerate
endmodule

bind reg_busy_sb reg_busy_sb_chk #(
   .NUM_ENT (NUM_ENT),
   .NUM_WP  (NUM_WP),
   .NUM_SRC (NUM_SRC),
   .NUM_DST (NUM_DST)
) chk_i (
   .clk      (clk),
   .rst      (rst),
   .wr_en    (wr_en),
   .wr_sel   (wr_sel),
   .wr_val   (wr_val),
   .src_sel  (src_sel),
   .dst_sel  (dst_sel),
   .busy_vec (busy_vec),
   .hazard   (hazard)
);

// File: tb/reg_busy_sb_tb_top.sv
`timescale 1ns/1ps
module reg_busy_sb_tb_top;
   localparam int NE = 32;
   localparam int NW = 2;
   localparam int NS = 3;
   localparam int ND = 2;

   logic                   clk = 1'b0;
   logic                   rst;
   logic [NW-1:0]          wr_en;
   logic [NW-1:0][NE-1:0]  wr_sel;
   logic [NW-1:0]          wr_val;
   logic [NS-1:0][NE-1:0]  src_sel;
   logic [ND-1:0][NE-1:0]  dst_sel;
   logic [NE-1:0]          busy_vec;
   logic                   hazard;

   logic [NE-1:0] exp_busy;
   int n_vec = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   reg_busy_sb #(.NUM_ENT(NE), .NUM_WP(NW), .NUM_SRC(NS), .NUM_DST(ND)) dut_i (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_val(wr_val),
      .src_sel(src_sel), .dst_sel(dst_sel), .busy_vec(busy_vec), .hazard(hazard)
   );

   task automatic check(input bit ok, input string req,
                        input logic [NE-1:0] act, input logic [NE-1:0] expv);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   function automatic logic [NE-1:0] bit_of(input int k);
      return NE'(1) << k;
   endfunction

   task automatic quiet();
      wr_en   = '0;
      wr_sel  = '0;
      wr_val  = '0;
      src_sel = '0;
      dst_sel = '0;
   endtask

   // Drive one write cycle, check no early visibility, then check the result.
   task automatic write_raw(input logic [NW-1:0] en, input logic [NW-1:0][NE-1:0] sel,
                            input logic [NW-1:0] val, input string req);
      logic [NE-1:0] sm, cm;
      @(negedge clk);
      wr_en = en; wr_sel = sel; wr_val = val;
      #1;
      check(busy_vec === exp_busy, "R6 no bypass", busy_vec, exp_busy);
      sm = '0; cm = '0;
      for (int p = 0; p < NW; p++) begin
         if (en[p] &&  val[p]) sm |= sel[p];
         if (en[p] && !val[p]) cm |= sel[p];
      end
      exp_busy = (exp_busy & ~cm) | (sm & ~cm);
      @(posedge clk);
      #1;
      check(busy_vec === exp_busy, req, busy_vec, exp_busy);
      quiet();
   endtask

   task automatic write2(input bit e0, input int s0, input bit v0,
                         input bit e1, input int s1, input bit v1, input string req);
      logic [NW-1:0][NE-1:0] sel;
      sel[0] = bit_of(s0);
      sel[1] = bit_of(s1);
      write_raw({e1, e0}, sel, {v1, v0}, req);
   endtask

   task automatic hz(input logic [NS-1:0][NE-1:0] s, input logic [ND-1:0][NE-1:0] d,
                     input string req);
      logic [NE-1:0] all;
      logic          expv;
      @(negedge clk);
      src_sel = s; dst_sel = d;
      #1;
      all  = s[0] | s[1] | s[2] | d[0] | d[1];
      expv = |(all & exp_busy);
      check(hazard === expv, req, NE'(hazard), NE'(expv));
      quiet();
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      #1;
      exp_busy = '0;
      check(busy_vec === '0, "R1 reset", busy_vec, '0);
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      #(5.0 * 150000);
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [NE-1:0] pat;
      logic [NS-1:0][NE-1:0] s;
      logic [ND-1:0][NE-1:0] d;
      logic [NW-1:0][NE-1:0] selx;
      quiet();
      rst = 1'b1;
      exp_busy = '0;
      repeat (3) @(posedge clk);
      #1;
      check(busy_vec === '0, "R1 initial reset", busy_vec, '0);
      @(negedge clk);
      rst = 1'b0;

      // R2: claim each entry through alternating ports.
      for (int k = 0; k < NE; k++)
         write2(k % 2 == 0, k, 1'b1, k % 2 == 1, k, 1'b1, "R2 set");
      check(busy_vec === '1, "R2 all busy", busy_vec, '1);

      // R9: idle cycles keep the state.
      repeat (6) @(posedge clk);
      #1;
      check(busy_vec === exp_busy, "R9 hold", busy_vec, exp_busy);

      // R3: release each entry through alternating ports.
      for (int k = 0; k < NE; k++)
         write2(k % 2 == 1, k, 1'b0, k % 2 == 0, k, 1'b0, "R3 clear");

      // R4: two distinct entries per cycle, claim then release.
      for (int i = 0; i < NE; i++) begin
         int j = (i * 7 + 3) % NE;
         write2(1'b1, i, 1'b1, 1'b1, j, 1'b1, "R4 dual set");
         write2(1'b1, j, 1'b0, 1'b1, i, 1'b0, "R4 dual clear");
      end
      // Mixed: port0 claims i while port1 releases another.
      for (int i = 0; i < NE; i++)
         write2(1'b1, i, 1'b1, 1'b1, (i + 5) % NE, 1'b0, "R4 set and clear");

      // R5: collisions on one entry, both port orders, from both states.
      for (int i = 0; i < NE; i++) begin
         write2(1'b1, i, 1'b1, 1'b0, 0, 1'b0, "R5 prefill");
         write2(1'b1, i, 1'b1, 1'b1, i, 1'b0, "R5 clear on port1 wins");
         write2(1'b1, i, 1'b0, 1'b1, i, 1'b1, "R5 clear on port0 wins");
      end

      // R7: disabled ports with full selections and both data values.
      do_reset();
      for (int k = 0; k < NE; k += 3) write2(1'b1, k, 1'b1, 1'b0, 0, 1'b0, "R7 setup");
      selx[0] = '1;
      selx[1] = '1;
      write_raw(2'b00, selx, 2'b00, "R7 disabled clear");
      write_raw(2'b00, selx, 2'b11, "R7 disabled set");
      write_raw(2'b00, selx, 2'b01, "R7 disabled mixed");

      // R1: reset from a nonzero state.
      do_reset();

      // R8: every operand slot against every entry on a mixed pattern.
      pat = 32'h8C31_52A7;
      for (int k = 0; k < NE; k++)
         if (pat[k]) write2(1'b0, 0, 1'b0, 1'b1, k, 1'b1, "R8 setup");
      check(busy_vec === pat, "R8 pattern", busy_vec, pat);
      for (int slot = 0; slot < NS + ND; slot++) begin
         for (int k = 0; k < NE; k++) begin
            s = '0; d = '0;
            if (slot < NS) s[slot] = bit_of(k);
            else           d[slot-NS] = bit_of(k);
            hz(s, d, "R8 single operand");
         end
      end
      // Full instruction shapes: three free sources, then one busy destination.
      s = '0; d = '0;
      hz(s, d, "R8 no operands");
      s[0] = bit_of(3); s[1] = bit_of(3); s[2] = bit_of(4);
      d[0] = bit_of(6); d[1] = bit_of(11);
      hz(s, d, "R8 all free");
      d[1] = bit_of(31);
      hz(s, d, "R8 busy destination");
      // Writes in the same cycle do not alter the hazard seen now (R6).
      @(negedge clk);
      src_sel[0] = bit_of(3);
      wr_en = 2'b01; wr_sel[0] = bit_of(3); wr_val = 2'b01;
      #1;
      check(hazard === 1'b0, "R6 hazard no bypass", NE'(hazard), '0);
      @(posedge clk);
      #1;
      exp_busy[3] = 1'b1;
      wr_en = '0;
      check(hazard === 1'b1, "R6 hazard after edge", NE'(hazard), NE'(1));
      quiet();

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule